// File: doc/BRIEF.md
# DDR Write Burst Sequencer

This block sits on the controller side of a double-data-rate memory link and turns write requests into a WRITE command plus the matching strobe, data and mask streams. Each request names a bank, a starting column, a burst length and whether the row closes automatically when the burst ends. The command leaves one cycle after the request. Data pairs are then pulled from the requester one per clock through a take strobe and driven out one cycle later. Each output cycle carries a rise-edge beat and a fall-edge beat on separate lanes. The mask bits are the inverse of the byte write enables supplied with each beat.

The strobe is held driven-low for one cycle before the first data pair (preamble) and for one cycle after the last (postamble). In between it toggles once per clock. A new write may arrive in any cycle. If it arrives x cycles after the previous one, the previous burst contributes exactly x pairs, so the data stream stays gap-free whether the earlier burst had already finished or is cut short. Two recovery counters start after the last data cycle. They hold the read-release and precharge-release signals low for the write-to-read and write-recovery times, given in clock cycles.

Top module: `ddrw_seq`

## Requirements
- R1: A request with `req_valid` high produces `cmd_wr` high in the next cycle, with `cmd_bank`, `cmd_col` and `cmd_ap` equal to the request's fields. With no request, `cmd_wr` is low.
- R2: The burst length code sets how many data pairs a write takes: 00 gives 1 pair, 01 gives 2, 10 gives 4, and 11 is treated as 4. `wd_take` is high for that many consecutive cycles, starting in the command cycle.
- R3: The command cycle of a write that starts from idle is a preamble: `dqs_oe` high, `dqs_tog` low, `dq_oe` low.
- R4: The data pair sampled from `wd_rise`/`wd_fall` in a cycle where `wd_take` is high appears on `dq_rise`/`dq_fall` in the next cycle, with `dq_oe` and `dqs_tog` high.
- R5: Each mask bit is the inverse of the matching byte write enable sampled with that beat (`dm_rise = ~we_rise`, `dm_fall = ~we_fall`). Bit i covers byte i, bits [8i+7:8i] of the lane.
- R6: The cycle after the last data pair is a postamble (`dqs_oe` high, `dqs_tog` low). After that `dqs_oe` is low. Whenever `dq_oe` is low, the data lanes and mask bits read zero.
- R7: A write issued x cycles after the previous one, with x no greater than that burst's pair count, leaves the earlier burst x data pairs. The data then continues without a gap cycle and without a new preamble.
- R8: `rd_allow` is low while a write is in flight (command cycle, take cycles, data cycles). It stays low for TWTR further cycles after the last data cycle, then rises.
- R9: `pre_allow` follows the same rule as R8 with TWR cycles in place of TWTR.
- R10: While `rst` is high, and in the first cycle after it falls with no request, `cmd_wr`, `wd_take`, `dq_oe` and `dqs_oe` are low, and `rd_allow` and `pre_allow` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request this cycle |
| req_bank | input | BANK_W | Bank of the request |
| req_col | input | COL_W | Starting column |
| req_len | input | 2 | Burst length code |
| req_ap | input | 1 | Close row after the burst |
| cmd_wr | output | 1 | WRITE command issued this cycle |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_col | output | COL_W | Column of the command |
| cmd_ap | output | 1 | Auto-close flag of the command |
| wd_take | output | 1 | Write data pair is sampled at the end of this cycle |
| wd_rise | input | DQ_W | Rise-edge beat to write |
| wd_fall | input | DQ_W | Fall-edge beat to write |
| we_rise | input | NBYTE | Byte enables of the rise beat |
| we_fall | input | NBYTE | Byte enables of the fall beat |
| dq_oe | output | 1 | Data lanes driven this cycle |
| dq_rise | output | DQ_W | Rise-edge data lane |
| dq_fall | output | DQ_W | Fall-edge data lane |
| dm_rise | output | NBYTE | Rise-edge mask bits |
| dm_fall | output | NBYTE | Fall-edge mask bits |
| dqs_oe | output | 1 | Strobe driven this cycle |
| dqs_tog | output | 1 | Strobe rises then falls this cycle |
| rd_allow | output | 1 | A READ may be released |
| pre_allow | output | 1 | A PRECHARGE may be released |

## Verification
The assertions cover the rules that hold on every cycle. Each command is followed by data in the next cycle, and data starting from idle is preceded by a command cycle. A drop of data is followed by a postamble, undriven lanes stay at zero, and both release signals stay low while data moves and just after the last pair. The bench scenarios cover what depends on a burst's history. That includes the pair count for each length code, the order of data values across lanes, and the mask polarity. It also includes the exact lengths of the recovery windows and how many pairs an earlier burst keeps when a later write chains onto it or cuts it short.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

    localparam int BANK_W = 2;
    localparam int COL_W  = 10;
    localparam int DQ_W   = 16;
    localparam int NBYTE  = DQ_W / 8;
    localparam int PAIR_W = 3;

    typedef enum logic [1:0] {
        LEN_2  = 2'b00,
        LEN_4  = 2'b01,
        LEN_8  = 2'b10,
        LEN_8X = 2'b11
    } blen_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
    } wcmd_t;

    typedef struct packed {
        logic [DQ_W-1:0]  rise;
        logic [DQ_W-1:0]  fall;
        logic [NBYTE-1:0] mrise;
        logic [NBYTE-1:0] mfall;
    } pair_t;

    function automatic logic [PAIR_W-1:0] pairs_of(input blen_e len);
        case (len)
            LEN_2:   return PAIR_W'(1);
            LEN_4:   return PAIR_W'(2);
            default: return PAIR_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/ddrw_cmd.sv
module ddrw_cmd
    import ddrw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  valid,
    input  wcmd_t req,
    output logic  cmd_wr,
    output wcmd_t cmd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_wr <= 1'b0;
            cmd    <= '0;
        end else begin
            cmd_wr <= valid;
            cmd    <= valid ? req : '0;
        end
    end

endmodule

// File: rtl/ddrw_beat.sv
module ddrw_beat
    import ddrw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PAIR_W-1:0] start_pairs,
    input  pair_t             in_pair,
    output logic              take,
    output logic              last,
    output logic              dq_oe,
    output logic              post,
    output pair_t             out_pair
);

    logic [PAIR_W-1:0] rem;

    assign take = (rem != '0);
    assign last = dq_oe && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (start) begin
            rem <= start_pairs;
        end else if (take) begin
            rem <= rem - PAIR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_oe    <= 1'b0;
            post     <= 1'b0;
            out_pair <= '0;
        end else begin
            dq_oe    <= take;
            post     <= last;
            out_pair <= take ? in_pair : '0;
        end
    end

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        rem <= PAIR_W'(4)); // R2

    AST_TAKE_RUN: assert property (@(posedge clk) disable iff (rst)
        (take && !start && rem > PAIR_W'(1)) |=> take); // R2

endmodule

// File: rtl/ddrw_gap.sv
module ddrw_gap #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic busy,
    output logic allow
);

    localparam int CW = (GAP < 1) ? 1 : $clog2(GAP + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(GAP);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign allow = (cnt == '0) && !busy;

endmodule

// File: rtl/ddrw_seq.sv
module ddrw_seq
    import ddrw_pkg::*;
#(
    parameter int TWTR = 2,
    parameter int TWR  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        req_len,
    input  logic              req_ap,
    output logic              cmd_wr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              wd_take,
    input  logic [DQ_W-1:0]   wd_rise,
    input  logic [DQ_W-1:0]   wd_fall,
    input  logic [NBYTE-1:0]  we_rise,
    input  logic [NBYTE-1:0]  we_fall,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_rise,
    output logic [DQ_W-1:0]   dq_fall,
    output logic [NBYTE-1:0]  dm_rise,
    output logic [NBYTE-1:0]  dm_fall,
    output logic              dqs_oe,
    output logic              dqs_tog,
    output logic              rd_allow,
    output logic              pre_allow
);

    wcmd_t req_s;
    wcmd_t cmd_s;
    pair_t in_s;
    pair_t out_s;
    logic  last_s;
    logic  post_s;
    logic  busy_s;

    assign req_s = '{bank: req_bank, col: req_col, ap: req_ap};
    assign in_s  = '{rise: wd_rise, fall: wd_fall, mrise: ~we_rise, mfall: ~we_fall};

    ddrw_cmd u_cmd (
        .clk    (clk),
        .rst    (rst),
        .valid  (req_valid),
        .req    (req_s),
        .cmd_wr (cmd_wr),
        .cmd    (cmd_s)
    );

    ddrw_beat u_beat (
        .clk         (clk),
        .rst         (rst),
        .start       (req_valid),
        .start_pairs (pairs_of(blen_e'(req_len))),
        .in_pair     (in_s),
        .take        (wd_take),
        .last        (last_s),
        .dq_oe       (dq_oe),
        .post        (post_s),
        .out_pair    (out_s)
    );

    assign busy_s = cmd_wr | wd_take | dq_oe;

    ddrw_gap #(.GAP(TWTR)) u_wtr (
        .clk   (clk),
        .rst   (rst),
        .load  (last_s),
        .busy  (busy_s),
        .allow (rd_allow)
    );

    ddrw_gap #(.GAP(TWR)) u_wr (
        .clk   (clk),
        .rst   (rst),
        .load  (last_s),
        .busy  (busy_s),
        .allow (pre_allow)
    );

    assign cmd_bank = cmd_s.bank;
    assign cmd_col  = cmd_s.col;
    assign cmd_ap   = cmd_s.ap;
    assign dq_rise  = out_s.rise;
    assign dq_fall  = out_s.fall;
    assign dm_rise  = out_s.mrise;
    assign dm_fall  = out_s.mfall;
    assign dqs_oe   = cmd_wr | dq_oe | post_s;
    assign dqs_tog  = dq_oe;

    AST_CMD_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> $past(req_valid)); // R1

    AST_CMD_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> dq_oe); // R4

    AST_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(cmd_wr) && $past(dqs_oe) && !$past(dqs_tog)); // R3

    AST_POSTAMBLE: assert property (@(posedge clk) disable iff (rst)
        $fell(dq_oe) |-> dqs_oe && !dqs_tog); // R6

    AST_QUIET_LANES: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_rise == '0) && (dq_fall == '0) && (dm_rise == '0) && (dm_fall == '0)); // R6

    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (dq_oe || cmd_wr) |-> !rd_allow && !pre_allow); // R8

    generate
        if (TWTR > 0) begin : g_wtr_chk
            AST_WTR_HOLD: assert property (@(posedge clk) disable iff (rst)
                $fell(dq_oe) |-> !rd_allow); // R8
        end
        if (TWR > 0) begin : g_wr_chk
            AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
                $fell(dq_oe) |-> !pre_allow); // R9
        end
    endgenerate

endmodule

// File: tb/tb_ddrw_seq.sv
module tb_ddrw_seq;
    import ddrw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int TWTR = 2;
    localparam int TWR  = 3;

    typedef struct packed {
        logic [1:0]        len;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
        logic [3:0]        pairs;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{2'b00, 2'd0, 10'h000, 1'b0, 4'd1},
        '{2'b01, 2'd1, 10'h004, 1'b1, 4'd2},
        '{2'b10, 2'd2, 10'h3F8, 1'b0, 4'd4},
        '{2'b11, 2'd3, 10'h120, 1'b1, 4'd4},
        '{2'b01, 2'd2, 10'h2AC, 1'b0, 4'd2},
        '{2'b10, 2'd0, 10'h010, 1'b1, 4'd4}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [1:0]        req_len = '0;
    logic              req_ap = 1'b0;
    logic              cmd_wr, cmd_ap, wd_take, dq_oe, dqs_oe, dqs_tog, rd_allow, pre_allow;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0]  cmd_col;
    logic [DQ_W-1:0]   wd_rise, wd_fall, dq_rise, dq_fall;
    logic [NBYTE-1:0]  we_rise, we_fall, dm_rise, dm_fall;

    int n_chk = 0;
    int n_fail = 0;
    int tk = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DQ_W-1:0] xr(input int g);
        return DQ_W'(16'h1000 + g * 2);
    endfunction
    function automatic logic [DQ_W-1:0] xf(input int g);
        return DQ_W'(16'h1000 + g * 2 + 1);
    endfunction
    function automatic logic [NBYTE-1:0] er(input int g);
        return g[0] ? 2'b01 : 2'b11;
    endfunction
    function automatic logic [NBYTE-1:0] ef(input int g);
        return g[1] ? 2'b10 : 2'b00;
    endfunction

    assign wd_rise = xr(tk);
    assign wd_fall = xf(tk);
    assign we_rise = er(tk);
    assign we_fall = ef(tk);

    always @(posedge clk) begin
        if (rst) tk <= 0;
        else if (wd_take) tk <= tk + 1;
    end

    ddrw_seq #(.TWTR(TWTR), .TWR(TWR)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bank(req_bank),
        .req_col(req_col), .req_len(req_len), .req_ap(req_ap),
        .cmd_wr(cmd_wr), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .wd_take(wd_take), .wd_rise(wd_rise), .wd_fall(wd_fall),
        .we_rise(we_rise), .we_fall(we_fall), .dq_oe(dq_oe),
        .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
        .dqs_oe(dqs_oe), .dqs_tog(dqs_tog), .rd_allow(rd_allow), .pre_allow(pre_allow)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pair(input int g, input string req);
        chk(dq_oe && dqs_oe && dqs_tog, {req, " R4 drive"}, {dq_oe, dqs_oe, dqs_tog}, 3'b111);
        chk(dq_rise == xr(g) && dq_fall == xf(g), {req, " R4 data"}, {dq_rise, dq_fall}, {xr(g), xf(g)});
        chk(dm_rise == ~er(g) && dm_fall == ~ef(g), {req, " R5 mask"}, {dm_rise, dm_fall}, {~er(g), ~ef(g)});
    endtask

    task automatic chk_post_and_gaps();
        int lo_r = 0;
        int lo_p = 0;
        chk(dqs_oe && !dqs_tog && !dq_oe, "R6 postamble", {dqs_oe, dqs_tog, dq_oe}, 3'b100);
        chk(dq_rise == '0 && dm_rise == '0 && dm_fall == '0, "R6 quiet lanes", {dq_rise, dm_rise, dm_fall}, '0);
        for (int i = 0; i < 10; i++) begin
            if (!rd_allow) lo_r++;
            if (!pre_allow) lo_p++;
            @(negedge clk);
            if (i == 0) chk(!dqs_oe, "R6 strobe released", dqs_oe, 0);
        end
        chk(lo_r == TWTR, "R8 write-to-read gap", lo_r, TWTR);
        chk(lo_p == TWR, "R9 write recovery gap", lo_p, TWR);
    endtask

    task automatic put_req(input vec_t v);
        req_valid = 1'b1;
        req_len   = v.len;
        req_bank  = v.bank;
        req_col   = v.col;
        req_ap    = v.ap;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        int takes;
        repeat (3) @(negedge clk);
        // R10: state while reset is held
        chk(!cmd_wr && !wd_take && !dq_oe && !dqs_oe, "R10 reset outputs",
            {cmd_wr, wd_take, dq_oe, dqs_oe}, 4'b0);
        chk(rd_allow && pre_allow, "R10 reset allows", {rd_allow, pre_allow}, 2'b11);
        rst = 1'b0;
        @(negedge clk);
        chk(!cmd_wr && !dqs_oe && rd_allow && pre_allow, "R10 idle after reset",
            {cmd_wr, dqs_oe, rd_allow, pre_allow}, 4'b0011);

        // Table walk: single bursts of each length code
        foreach (VEC[k]) begin
            put_req(VEC[k]);
            chk(rd_allow, "R8 allow before request", rd_allow, 1);
            @(negedge clk);
            req_valid = 1'b0;
            base = tk;
            chk(cmd_wr && cmd_bank == VEC[k].bank && cmd_col == VEC[k].col && cmd_ap == VEC[k].ap,
                "R1 command fields", {cmd_wr, cmd_bank, cmd_col, cmd_ap},
                {1'b1, VEC[k].bank, VEC[k].col, VEC[k].ap});
            chk(dqs_oe && !dqs_tog && !dq_oe, "R3 preamble", {dqs_oe, dqs_tog, dq_oe}, 3'b100);
            chk(!rd_allow && !pre_allow, "R8 R9 blocked in command cycle", {rd_allow, pre_allow}, 2'b00);
            takes = 0;
            for (int p = 0; p < int'(VEC[k].pairs); p++) begin
                if (wd_take) takes++;
                @(negedge clk);
                chk(!cmd_wr, "R1 single command", cmd_wr, 0);
                chk_pair(base + p, "table");
            end
            chk(takes == int'(VEC[k].pairs) && !wd_take, "R2 pair count", takes, VEC[k].pairs);
            @(negedge clk);
            chk_post_and_gaps();
        end

        // R7: chaining, second write two cycles after a 2-pair burst
        put_req('{2'b01, 2'd1, 10'h040, 1'b0, 4'd2});
        @(negedge clk);
        req_valid = 1'b0;
        base = tk;
        chk(dqs_oe && !dqs_tog, "R3 preamble chain", {dqs_oe, dqs_tog}, 2'b10);
        @(negedge clk);
        chk_pair(base, "R7 chain A0");
        put_req('{2'b01, 2'd2, 10'h080, 1'b1, 4'd2});
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_wr && cmd_bank == 2'd2 && cmd_col == 10'h080, "R7 chained command",
            {cmd_wr, cmd_bank, cmd_col}, {1'b1, 2'd2, 10'h080});
        chk_pair(base + 1, "R7 chain A1 no preamble");
        @(negedge clk);
        chk_pair(base + 2, "R7 chain B0");
        @(negedge clk);
        chk_pair(base + 3, "R7 chain B1");
        @(negedge clk);
        chk_post_and_gaps();

        // R7: truncation, 4-pair burst cut to one pair
        put_req('{2'b10, 2'd3, 10'h100, 1'b0, 4'd4});
        @(negedge clk);
        base = tk;
        put_req('{2'b00, 2'd1, 10'h104, 1'b0, 4'd1});
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_wr && cmd_col == 10'h104, "R7 truncating command", {cmd_wr, cmd_col}, {1'b1, 10'h104});
        chk_pair(base, "R7 truncated A0");
        @(negedge clk);
        chk_pair(base + 1, "R7 follow-on B0");
        chk(!wd_take, "R7 truncated take stops", wd_take, 0);
        @(negedge clk);
        chk(tk == base + 2, "R7 truncated pair total", tk, base + 2);
        chk_post_and_gaps();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule